// File: doc/BRIEF.md
# Timeslot Power Rail Sequencer

This block governs the power state of a small group of outputs: regulator enables, a clock-output enable and external enable pins. Each output carries four small slot fields. One places it in the power-up sequence, one in the shutdown sequence, one in the sleep sequence and one in the wake sequence. A field can also hold "none". When the controller receives a power-up, shutdown, sleep or wake event, it walks through five timeslots. The slots are spaced by a programmable interval. In each slot it raises or lowers every output assigned to that slot.

Power-up and sleep walk the slots upward. Shutdown and wake walk them downward. Because the shutdown and wake fields are separate inputs, software may rewrite them while the block sits in ON or SLEEP, so the reverse order need not mirror the forward one.

Outputs without a power-up slot can be handed to a hardware enable pin. Outputs not under hardware control can be switched by software pulses while ON. One designated output can be held on through shutdown.

A power-up request is honoured only while the supply-OK input is high. Events that arrive during a running sequence are held and acted on when the sequence ends, with shutdown winning over any other event.

Top module: `pwr_seq`

## Requirements
- R1: After a power-up event is accepted in OFF, the outputs whose power-up field equals k (k = 1..5) turn on exactly k*(slot_gap+1) cycles after the block enters SEQ_ON. A field value of 0, or any value above 5, means no slot.
- R2: A power-up event seen while supply_ok is low is discarded, not held. The block stays in OFF even after supply_ok later rises.
- R3: A shutdown event from ON or SLEEP visits the slots from 5 down to 1. In the j-th visited slot (j = 1..5), at j*(slot_gap+1) cycles after entry, it turns off the outputs whose shutdown field equals that slot. The sequence ends in OFF with every output low except the held output.
- R4: The shutdown fields may be changed while ON, and the next shutdown follows the new fields rather than the power-up order.
- R5: A sleep event in ON turns off outputs by their sleep field in slots 1 to 5. A wake event in SLEEP turns outputs back on by their wake field in slots 5 down to 1. Both use the same j*(slot_gap+1) spacing, and wake fields written during SLEEP take effect.
- R6: On entry to SEQ_OFF, every output with no power-up slot drops on the very next cycle, including those under hardware control. The exception is output KEEP_IDX (index 5 by default): while keep_on is high, it is driven high in OFF and SEQ_OFF.
- R7: An output with hw_sel set and no power-up slot follows hw_pin in ON, SEQ_SLEEP, SLEEP and SEQ_WAKE, is low in the other states, and ignores software pulses.
- R8: In ON, a pulse on sw_set[i] or sw_clr[i] turns output i on or off one cycle later, for any output not under hardware control.
- R9: Events arriving during a sequence are held until it ends. If a shutdown and another event are both held, the shutdown is taken and the rest are discarded.
- R10: pwr_state encodes OFF=0, SEQ_ON=1, ON=2, SEQ_SLEEP=3, SLEEP=4, SEQ_WAKE=5, SEQ_OFF=6. Reset gives OFF with all outputs low. seq_done is high for exactly the one cycle in which the block first shows the state a sequence ends in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply above threshold; gates power-up |
| ev_on | input | 1 | Power-up event pulse |
| ev_off | input | 1 | Shutdown event pulse |
| ev_sleep | input | 1 | Sleep event pulse |
| ev_wake | input | 1 | Wake event pulse |
| slot_gap | input | TMR_W | Cycles between slots, minus one |
| on_slot | input | N_OUT*SLOT_W | Power-up slot field per output |
| off_slot | input | N_OUT*SLOT_W | Shutdown slot field per output |
| sleep_slot | input | N_OUT*SLOT_W | Sleep slot field per output |
| wake_slot | input | N_OUT*SLOT_W | Wake slot field per output |
| sw_set | input | N_OUT | Software turn-on pulses (ON only) |
| sw_clr | input | N_OUT | Software turn-off pulses (ON only) |
| hw_sel | input | N_OUT | Hand unslotted output to hardware pin |
| hw_pin | input | N_OUT | Hardware enable pin levels |
| keep_on | input | 1 | Hold output KEEP_IDX on in OFF |
| rail_en | output | N_OUT | Output enables |
| pwr_state | output | 3 | Current power state |
| seq_done | output | 1 | One-cycle pulse at end of a sequence |

## Verification
The sequences are driven with slot assignments that include an empty top slot, a reversed shutdown table and a reshuffled wake table. Checking each output one cycle before and at its slot edge separates ascending from descending stepping and catches off-by-one spacing. A rejected power-up followed by a late supply_ok rise shows that refused events are dropped rather than held. Wake and shutdown queued together during a sleep sequence show that queued events wait for the sequence to end and that shutdown wins. Toggling software pulses and the hardware pin on both kinds of output shows which control owns each output.

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int N_OUT    = 6,
  parameter int N_SLOT   = 5,
  parameter int SLOT_W   = 3,
  parameter int TMR_W    = 8,
  parameter int KEEP_IDX = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     supply_ok,
  input  logic                     ev_on,
  input  logic                     ev_off,
  input  logic                     ev_sleep,
  input  logic                     ev_wake,
  input  logic [TMR_W-1:0]         slot_gap,
  input  logic [N_OUT*SLOT_W-1:0]  on_slot,
  input  logic [N_OUT*SLOT_W-1:0]  off_slot,
  input  logic [N_OUT*SLOT_W-1:0]  sleep_slot,
  input  logic [N_OUT*SLOT_W-1:0]  wake_slot,
  input  logic [N_OUT-1:0]         sw_set,
  input  logic [N_OUT-1:0]         sw_clr,
  input  logic [N_OUT-1:0]         hw_sel,
  input  logic [N_OUT-1:0]         hw_pin,
  input  logic                     keep_on,
  output logic [N_OUT-1:0]         rail_en,
  output logic [2:0]               pwr_state,
  output logic                     seq_done
);

  localparam logic [2:0] S_OFF = 3'd0, S_SEQ_ON = 3'd1, S_ON = 3'd2, S_SEQ_SLEEP = 3'd3,
                         S_SLEEP = 3'd4, S_SEQ_WAKE = 3'd5, S_SEQ_OFF = 3'd6;
  localparam logic [SLOT_W-1:0] FIRST = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] LAST  = SLOT_W'(N_SLOT);
  localparam logic [N_OUT-1:0]  KEEP_MASK = N_OUT'(1) << KEEP_IDX;

  logic [2:0]        state;
  logic [TMR_W-1:0]  tmr;
  logic [SLOT_W-1:0] slot;
  logic [3:0]        pend;
  logic [N_OUT-1:0]  rail_q, hit, unslot, hw_ctl;

  wire [3:0] req    = pend | {ev_wake, ev_sleep, ev_off, ev_on};
  wire       tick   = (tmr == slot_gap);
  wire       rev    = (state == S_SEQ_OFF) || (state == S_SEQ_WAKE);
  wire       rise   = (state == S_SEQ_ON) || (state == S_SEQ_WAKE);
  wire       last   = rev ? (slot == FIRST) : (slot == LAST);
  wire       hw_live = (state == S_ON) || (state == S_SEQ_SLEEP) ||
                       (state == S_SLEEP) || (state == S_SEQ_WAKE);
  wire       keep_live = keep_on && ((state == S_OFF) || (state == S_SEQ_OFF));

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    logic [SLOT_W-1:0] fld, on_f;
    assign on_f = on_slot[i*SLOT_W +: SLOT_W];
    assign unslot[i] = (on_f == '0) || (on_f > LAST);
    assign hw_ctl[i] = hw_sel[i] && unslot[i];
    always_comb begin
      case (state)
        S_SEQ_ON:    fld = on_f;
        S_SEQ_OFF:   fld = off_slot[i*SLOT_W +: SLOT_W];
        S_SEQ_SLEEP: fld = sleep_slot[i*SLOT_W +: SLOT_W];
        default:     fld = wake_slot[i*SLOT_W +: SLOT_W];
      endcase
    end
    assign hit[i] = (fld == slot);
  end

  assign rail_en = (rail_q & ~hw_ctl) | (hw_pin & hw_ctl & {N_OUT{hw_live}}) |
                   (KEEP_MASK & {N_OUT{keep_live}});
  assign pwr_state = state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_OFF;
      tmr      <= '0;
      slot     <= '0;
      pend     <= '0;
      rail_q   <= '0;
      seq_done <= 1'b0;
    end else begin
      seq_done <= 1'b0;
      case (state)
        S_OFF: begin
          pend <= '0;
          if (req[0] && supply_ok) begin
            state  <= S_SEQ_ON;
            tmr    <= '0;
            slot   <= FIRST;
            rail_q <= '0;
          end
        end
        S_ON: begin
          pend <= '0;
          if (req[1]) begin
            state  <= S_SEQ_OFF;
            tmr    <= '0;
            slot   <= LAST;
            rail_q <= rail_q & ~unslot;
          end else if (req[2]) begin
            state <= S_SEQ_SLEEP;
            tmr   <= '0;
            slot  <= FIRST;
          end else begin
            rail_q <= (rail_q | (sw_set & ~hw_ctl)) & ~(sw_clr & ~hw_ctl);
          end
        end
        S_SLEEP: begin
          pend <= '0;
          if (req[1]) begin
            state  <= S_SEQ_OFF;
            tmr    <= '0;
            slot   <= LAST;
            rail_q <= rail_q & ~unslot;
          end else if (req[3]) begin
            state <= S_SEQ_WAKE;
            tmr   <= '0;
            slot  <= LAST;
          end
        end
        default: begin
          pend <= req;
          if (tick) begin
            tmr    <= '0;
            rail_q <= rise ? (rail_q | hit) : (rail_q & ~hit);
            if (last) begin
              seq_done <= 1'b1;
              case (state)
                S_SEQ_ON, S_SEQ_WAKE: state <= S_ON;
                S_SEQ_SLEEP:          state <= S_SLEEP;
                default: begin
                  state  <= S_OFF;
                  rail_q <= '0;
                end
              endcase
            end else begin
              slot <= rev ? slot - SLOT_W'(1) : slot + SLOT_W'(1);
            end
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
      endcase
    end
  end

  wire in_seq = (state == S_SEQ_ON) || (state == S_SEQ_OFF) ||
                (state == S_SEQ_SLEEP) || (state == S_SEQ_WAKE);

  assert_legal_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state <= S_SEQ_OFF);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);
  assert_on_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OFF && !supply_ok) |=> state == S_OFF);
  assert_up_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SEQ_ON) |=> (($past(rail_q) & ~rail_q) == '0));
  assert_down_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SEQ_OFF) |=> ((rail_q & ~$past(rail_q)) == '0));
  assert_slot_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_seq && !tick) |=> $stable(rail_q));
  assert_off_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OFF) |-> ((rail_en & ~KEEP_MASK) == '0));

endmodule

// File: tb/pwr_seq_bench.sv
`timescale 1ns/1ps
module pwr_seq_bench;
  localparam int N = 6;
  localparam int GAP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic supply_ok = 0, ev_on = 0, ev_off = 0, ev_sleep = 0, ev_wake = 0, keep_on = 0;
  logic [7:0] slot_gap = 8'(GAP);
  logic [N*3-1:0] on_slot, off_slot, sleep_slot, wake_slot;
  logic [N-1:0] sw_set = '0, sw_clr = '0, hw_sel = 6'b010000, hw_pin = '0;
  logic [N-1:0] rail_en;
  logic [2:0] pwr_state;
  logic seq_done;
  logic [2:0] on_t[N], off_t[N], slp_t[N], wk_t[N];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      on_slot[i*3 +: 3]    = on_t[i];
      off_slot[i*3 +: 3]   = off_t[i];
      sleep_slot[i*3 +: 3] = slp_t[i];
      wake_slot[i*3 +: 3]  = wk_t[i];
    end
  end

  pwr_seq u_pwr_seq (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ev_on(ev_on), .ev_off(ev_off),
    .ev_sleep(ev_sleep), .ev_wake(ev_wake), .slot_gap(slot_gap), .on_slot(on_slot),
    .off_slot(off_slot), .sleep_slot(sleep_slot), .wake_slot(wake_slot),
    .sw_set(sw_set), .sw_clr(sw_clr), .hw_sel(hw_sel), .hw_pin(hw_pin),
    .keep_on(keep_on), .rail_en(rail_en), .pwr_state(pwr_state), .seq_done(seq_done));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] slot_mask(input int kind, input int s);
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) begin
      logic [2:0] f;
      case (kind)
        0: f = on_t[i];
        1: f = off_t[i];
        2: f = slp_t[i];
        default: f = wk_t[i];
      endcase
      if (int'(f) == s) m[i] = 1'b1;
    end
    return m;
  endfunction

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_on = 1; 1: ev_off = 1; 2: ev_sleep = 1; default: ev_wake = 1;
    endcase
    @(negedge clk);
    {ev_on, ev_off, ev_sleep, ev_wake} = '0;
  endtask

  // called one negedge after the entry edge; returns at the final slot edge
  task automatic step_seq(input int kind, input bit set, input bit rev,
                          input logic [N-1:0] start, input string req, input logic [2:0] end_st);
    logic [N-1:0] exp = start;
    for (int j = 1; j <= 5; j++) begin
      int s = rev ? 6 - j : j;
      logic [N-1:0] m = slot_mask(kind, s);
      repeat (GAP) @(negedge clk);
      chk({req, " before slot"}, 32'(rail_en), 32'(exp));
      @(negedge clk);
      exp = set ? (exp | m) : (exp & ~m);
      chk({req, " at slot"}, 32'(rail_en), 32'(exp));
    end
    chk({req, " end state"}, 32'(pwr_state), 32'(end_st));
    chk("R10 done pulse", 32'(seq_done), 32'd1);
  endtask

  task automatic t_reset;
    chk("R10 reset state", 32'(pwr_state), 32'd0);
    chk("R10 reset rails", 32'(rail_en), 32'd0);
    chk("R10 reset done", 32'(seq_done), 32'd0);
  endtask

  task automatic t_on_rejected;
    supply_ok = 0;
    pulse(0);
    repeat (10) @(negedge clk);
    chk("R2 stays off", 32'(pwr_state), 32'd0);
    supply_ok = 1;
    repeat (10) @(negedge clk);
    chk("R2 not held", 32'(pwr_state), 32'd0);
    chk("R2 rails low", 32'(rail_en), 32'd0);
  endtask

  task automatic t_power_up;
    hw_pin = '0;
    pulse(0);
    chk("R1 entered SEQ_ON", 32'(pwr_state), 32'd1);
    step_seq(0, 1, 0, '0, "R1 power-up", 3'd2);
    @(negedge clk);
    chk("R10 done one cycle", 32'(seq_done), 32'd0);
  endtask

  task automatic t_on_controls;
    hw_pin[4] = 1;
    @(negedge clk);
    chk("R7 hw pin high", 32'(rail_en), 32'b011111);
    hw_pin[4] = 0;
    @(negedge clk);
    chk("R7 hw pin low", 32'(rail_en), 32'b001111);
    sw_set = 6'b010000;
    @(negedge clk); sw_set = '0;
    chk("R7 sw ignored on hw output", 32'(rail_en), 32'b001111);
    sw_clr = 6'b000001;
    @(negedge clk); sw_clr = '0;
    chk("R8 sw clear", 32'(rail_en), 32'b001110);
    sw_set = 6'b100001;
    @(negedge clk); sw_set = '0;
    chk("R8 sw set", 32'(rail_en), 32'b101111);
    sw_clr = 6'b100000;
    @(negedge clk); sw_clr = '0;
    chk("R8 sw clear unslotted", 32'(rail_en), 32'b001111);
    hw_pin[4] = 1;
  endtask

  task automatic t_sleep_wake;
    pulse(2);
    step_seq(2, 0, 0, 6'b011111, "R5 sleep", 3'd4);
    chk("R7 hw held in sleep", 32'(rail_en[4]), 32'd1);
    wk_t[1] = 3'd5; wk_t[2] = 3'd4; wk_t[3] = 3'd1;
    @(negedge clk);
    pulse(3);
    step_seq(3, 1, 1, 6'b010001, "R5 wake", 3'd2);
  endtask

  task automatic t_pending_keep;
    keep_on = 1;
    @(negedge clk);
    chk("R6 keep no effect in ON", 32'(rail_en), 32'b011111);
    pulse(2);
    ev_wake = 1; ev_off = 1;
    @(negedge clk);
    ev_wake = 0; ev_off = 0;
    repeat (14) @(negedge clk);
    chk("R9 sleep completes first", 32'(pwr_state), 32'd4);
    chk("R9 sleep rails", 32'(rail_en), 32'b010001);
    @(negedge clk);
    chk("R9 off wins", 32'(pwr_state), 32'd6);
    chk("R6 immediate drop", 32'(rail_en), 32'b100001);
    step_seq(1, 0, 1, 6'b100001, "R3 shutdown", 3'd0);
    chk("R6 keep held in OFF", 32'(rail_en), 32'b100000);
    repeat (5) @(negedge clk);
    chk("R9 wake discarded", 32'(pwr_state), 32'd0);
    keep_on = 0;
    @(negedge clk);
    chk("R6 keep released", 32'(rail_en), 32'd0);
  endtask

  task automatic t_reordered_off;
    hw_pin = '0;
    pulse(0);
    step_seq(0, 1, 0, '0, "R1 second power-up", 3'd2);
    off_t = '{3'd2, 3'd4, 3'd1, 3'd3, 3'd0, 3'd0};
    @(negedge clk);
    pulse(1);
    chk("R3 entered SEQ_OFF", 32'(pwr_state), 32'd6);
    step_seq(1, 0, 1, 6'b001111, "R4 reordered shutdown", 3'd0);
    chk("R3 all low", 32'(rail_en), 32'd0);
  endtask

  initial begin
    on_t  = '{3'd1, 3'd2, 3'd3, 3'd5, 3'd0, 3'd0};
    off_t = '{3'd1, 3'd2, 3'd3, 3'd5, 3'd0, 3'd0};
    slp_t = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 3'd0};
    wk_t  = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd0, 3'd0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_on_rejected();
    t_power_up();
    t_on_controls();
    t_sleep_wake();
    t_pending_keep();
    t_reordered_off();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule